// File: doc/BRIEF.md
# Floating-Point Status Exception Recorder

This block owns the 32-bit floating-point status word and folds each operation's exception outcome into it. An arithmetic unit that has finished an operation presents its five raised exception flags together with an update strobe. The block compares the flags with the trap-enable mask held in the same word and decides whether the operation traps. It then rewrites the current-exception field and, when there is no trap, ORs the flags into the accrued field. On a trap it instead keeps only the single most important enabled exception, marks an IEEE trap type in the word and raises a one-cycle trap request.

Software loads the whole word through a plain write port. A separate drain-completion input reports that the deferred-operation queue has been emptied. It clears the two queue-status bits, and it also clears the current-exception field when every queued operation completed without fault. All pins are plain control and status signals. The update strobe is a single-cycle event with no handshake, and the block accepts one update per cycle without ever stalling the producer.

Top module: `fpsr_recorder`

## Requirements
- R1: After reset the status word reads 0 and the trap request is low.
- R2: A write loads the whole 32-bit word on the next clock edge. A write cycle never raises the trap request.
- R3: An update traps exactly when some raised flag is also set in the enable mask (status bits 27:23, in the same flag order as the fields). The trap request is high for the one cycle that follows the update edge and is low otherwise.
- R4: Flag bits in every 5-bit field are invalid=4, overflow=3, underflow=2, divide-by-zero=1, inexact=0. On a trap the raised flags are ANDed with the mask first, and then only the highest-numbered remaining bit is written to the current field (bits 4:0).
- R5: On a non-trapping update the current field becomes the raised flags, and those flags are ORed into the accrued field (bits 9:5).
- R6: On a trapping update the accrued field is left unchanged and status bit 14 (IEEE trap type) is set.
- R7: An update with all flags zero clears the current field, leaves the accrued field unchanged and does not trap.
- R8: An update changes no status bits other than the current field, the accrued field and bit 14. A non-trapping update leaves bit 14 as it was.
- R9: A drain completion clears status bits 13:12. The current field is also cleared only when the drain reports success; otherwise it is kept.
- R10: When events coincide, a write takes precedence over an update, and an update takes precedence over a drain completion. The lower-precedence event in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the status word from wr_data |
| wr_data | input | 32 | Value to load |
| upd_valid | input | 1 | Update strobe for one finished operation |
| upd_flags | input | 5 | Exception flags raised by that operation |
| drain_done | input | 1 | Deferred-operation queue has been emptied |
| drain_ok | input | 1 | All drained operations completed without fault |
| status | output | 32 | Current status word |
| trap_req | output | 1 | One-cycle trap request following a trapping update |

## Verification
The block's state is the status word itself, which is driven directly to the ports. A wrong next-state choice therefore shows on `status` at the sample point right after the offending edge. A priority slip appears as a second set bit in the current field. A wrong trap decision appears as the accrued field changing when it should hold, or as a missing bit 14 and trap request. Trap-request timing is checked both on the cycle after the update and one cycle later, so a request that sticks or arrives late is caught within two cycles.

// File: rtl/fpsr_pkg.sv
package fpsr_pkg;
  localparam int FLAG_W   = 5;
  localparam int WORD_W   = 32;
  localparam int CUR_LSB  = 0;
  localparam int ACC_LSB  = 5;
  localparam int MASK_LSB = 23;
  localparam int TT_BIT   = 14;
  localparam int QS_LSB   = 12;
  localparam int QS_W     = 2;

  typedef logic [FLAG_W-1:0] flags_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fpsr_trap_arbiter.sv
module fpsr_trap_arbiter
  import fpsr_pkg::*;
(
  input  flags_t raised,
  input  flags_t enable,
  output logic   trap,
  output flags_t chosen
);
  flags_t masked;

  assign masked = raised & enable;
  assign trap   = |masked;

  // Highest-numbered enabled flag wins: invalid down to inexact.
  always_comb begin
    logic found;
    found  = 1'b0;
    chosen = '0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (masked[i] && !found) begin
        chosen[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpsr_next.sv
module fpsr_next
  import fpsr_pkg::*;
(
  input  word_t  cur,
  input  logic   wr_en,
  input  word_t  wr_data,
  input  logic   upd_valid,
  input  flags_t upd_flags,
  input  logic   drain_done,
  input  logic   drain_ok,
  output word_t  nxt,
  output logic   trap_nxt
);
  flags_t enable;
  flags_t chosen;
  logic   trap;

  assign enable = cur[MASK_LSB +: FLAG_W];

  fpsr_trap_arbiter u_arb (
    .raised (upd_flags),
    .enable (enable),
    .trap   (trap),
    .chosen (chosen)
  );

  always_comb begin
    nxt      = cur;
    trap_nxt = 1'b0;
    if (wr_en) begin
      nxt = wr_data;
    end else if (upd_valid) begin
      if (trap) begin
        nxt[CUR_LSB +: FLAG_W] = chosen;
        nxt[TT_BIT]            = 1'b1;
        trap_nxt               = 1'b1;
      end else begin
        nxt[CUR_LSB +: FLAG_W] = upd_flags;
        nxt[ACC_LSB +: FLAG_W] = cur[ACC_LSB +: FLAG_W] | upd_flags;
      end
    end else if (drain_done) begin
      nxt[QS_LSB +: QS_W] = '0;
      if (drain_ok) nxt[CUR_LSB +: FLAG_W] = '0;
    end
  end
endmodule

// File: rtl/fpsr_recorder.sv
module fpsr_recorder
  import fpsr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        upd_valid,
  input  logic [4:0]  upd_flags,
  input  logic        drain_done,
  input  logic        drain_ok,
  output logic [31:0] status,
  output logic        trap_req
);
  word_t word_q, word_d;
  logic  trap_d;

  fpsr_next u_next (
    .cur        (word_q),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .upd_valid  (upd_valid),
    .upd_flags  (upd_flags),
    .drain_done (drain_done),
    .drain_ok   (drain_ok),
    .nxt        (word_d),
    .trap_nxt   (trap_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      trap_req <= 1'b0;
    end else begin
      word_q   <= word_d;
      trap_req <= trap_d;
    end
  end

  assign status = word_q;

  AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $countones(status[CUR_LSB +: FLAG_W]) == 1); // R4
  AST_TRAP_KEEPS_ACCRUED: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> status[ACC_LSB +: FLAG_W] == $past(status[ACC_LSB +: FLAG_W])); // R6
  AST_TRAP_TYPE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> status[TT_BIT]); // R6
  AST_NO_SPURIOUS_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid || wr_en) |=> !trap_req); // R3
  AST_ACCRUED_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !wr_en) |=>
      ((status[ACC_LSB +: FLAG_W] & $past(status[ACC_LSB +: FLAG_W])) ==
        $past(status[ACC_LSB +: FLAG_W]))); // R5
  AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_done && !upd_valid && !wr_en) |=> status[QS_LSB +: QS_W] == '0); // R9
endmodule

// File: tb/fpsr_recorder_tb.sv
`timescale 1ns/1ps
module fpsr_recorder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        upd_valid = 1'b0;
  logic [4:0]  upd_flags = '0;
  logic        drain_done = 1'b0;
  logic        drain_ok = 1'b0;
  logic [31:0] status;
  logic        trap_req;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fpsr_recorder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .upd_valid(upd_valid), .upd_flags(upd_flags),
    .drain_done(drain_done), .drain_ok(drain_ok),
    .status(status), .trap_req(trap_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic cycle();
    @(negedge clk);
    wr_en = 1'b0; upd_valid = 1'b0; drain_done = 1'b0; drain_ok = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] v);
    wr_en = 1'b1; wr_data = v; cycle();
  endtask

  task automatic do_update(input logic [4:0] f);
    upd_valid = 1'b1; upd_flags = f; cycle();
  endtask

  task automatic do_drain(input logic ok);
    drain_done = 1'b1; drain_ok = ok; cycle();
  endtask

  task automatic t_reset();
    check("R1 status", status, 32'h0);
    check("R1 trap", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_write();
    do_write(32'hA5C3_0F96);
    check("R2 load", status, 32'hA5C3_0F96);
    check("R2 no trap", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_untrapped();
    do_write(32'h0);
    do_update(5'b00101);
    check("R5 first", status, 32'h0000_00A5);
    check("R3 no trap unmasked", {31'b0, trap_req}, 32'h0);
    do_update(5'b10000);
    check("R5 accrue or", status, 32'h0000_02B0);
  endtask

  task automatic t_zero();
    do_update(5'b00000);
    check("R7 zero flags", status, 32'h0000_02A0);
    check("R7 no trap", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_trap_priority();
    do_write(32'h0F80_0060);
    do_update(5'b01110);
    check("R4 overflow wins", status, 32'h0F80_4068);
    check("R3 trap pulse", {31'b0, trap_req}, 32'h1);
    cycle();
    check("R3 trap one cycle", {31'b0, trap_req}, 32'h0);
    do_update(5'b00011);
    check("R4 divzero over inexact", status, 32'h0F80_4062);
    do_update(5'b11111);
    check("R6 invalid wins, accrued held", status, 32'h0F80_4070);
  endtask

  task automatic t_partial_mask();
    do_write(32'h0080_0000);
    do_update(5'b10001);
    check("R4 mask before priority", status, 32'h0080_4001);
    check("R3 partial trap", {31'b0, trap_req}, 32'h1);
    do_update(5'b10000);
    check("R8 bit14 kept, R5 accrue", status, 32'h0080_4210);
    check("R3 disabled flag no trap", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_other_bits();
    do_write(32'hF07F_3C00);
    do_update(5'b00100);
    check("R8 other bits kept", status, 32'hF07F_3C84);
  endtask

  task automatic t_drain();
    do_drain(1'b0);
    check("R9 drain fail keeps current", status, 32'hF07F_0C84);
    do_write(32'hF07F_3C84);
    do_drain(1'b1);
    check("R9 drain ok clears current", status, 32'hF07F_0C80);
  endtask

  task automatic t_precedence();
    do_write(32'h0000_3000);
    wr_en = 1'b1; wr_data = 32'h1234_0000; upd_valid = 1'b1; upd_flags = 5'b11111;
    cycle();
    check("R10 write beats update", status, 32'h1234_0000);
    check("R10 no trap on write", {31'b0, trap_req}, 32'h0);
    do_write(32'h0000_3000);
    upd_valid = 1'b1; upd_flags = 5'b00001; drain_done = 1'b1; drain_ok = 1'b1;
    cycle();
    check("R10 update beats drain", status, 32'h0000_3021);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_untrapped();
        t_zero();
        t_trap_priority();
        t_partial_mask();
        t_other_bits();
        t_drain();
        t_precedence();
      end
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule